// File: doc/BRIEF.md
# Posted Store Buffer for a Multiplexed Write Bus

This block sits between a processor's store port and an external 32-bit bus that carries both address and data on the same pins. It takes in one store per clock while it has a free slot. Each store carries a word address, a data word and four byte enables. Stores leave in the order they arrived, and each one leaves as a two-phase bus write. In the first phase the block presents the upper address bits and the byte enables, together with a latch strobe. In the second phase it drives the data and asserts the write strobe until the memory side acknowledges the write or reports an error. The processor only sees a stall once every slot is occupied.

Each write is also tagged "near" when it lands in the same 1 KB page as the previous write that completed without error. Page-mode memory controllers can use this tag to retire the write faster. The history is forgotten after reset and after a write that ends in a bus error. The block never drives read data and never turns the data buffers of external memory on.

Top module: `store_post_buffer`

## Requirements
- R1: The buffer holds up to DEPTH (default four) stores and retires them strictly in acceptance order. `buf_count` is a registered occupancy count that is never above DEPTH.
- R2: `buf_full` and `st_stall` are high exactly when the count equals DEPTH. A store presented while `buf_full` is high is not taken, stays pending, and is taken once a slot frees. While not full, one store is taken every cycle that `st_valid` is high.
- R3: The address phase lasts one cycle with `ale` high, `wr` low and `ad_oe` high. In that cycle `ad_out[31:4]` equals store address bits 31:4, and `ad_out[3:0]` equals the byte enables, bit n active-high for byte lane n.
- R4: `addr_lo` carries store address bits 3:2 throughout both phases of the write.
- R5: The data phase follows the address phase directly. In it `ad_out` carries the store data with `wr` high, and both stay unchanged until `ack` or `berr` is high at a rising clock edge. That edge ends the write.
- R6: `wr_near` is high during both phases of a write exactly when the previous completed write ended with `ack`, not `berr`, and address bits 31:10 of the two writes are equal.
- R7: The first write after reset, and the first write after a write ended by `berr`, are never near.
- R8: `data_en` is low at all times. When no write is in progress, `ale`, `wr` and `ad_oe` are low.
- R9: A write ended by `berr` is removed from the buffer like an acknowledged one, and the next store proceeds normally.
- R10: When another store is waiting at the edge that ends a write, its address phase starts in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Processor presents a store |
| st_waddr | input | 30 | Store word address, bits 31:2 of the byte address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Byte enables, active high, bit n = byte lane n |
| st_stall | output | 1 | Buffer full, the presented store is not taken |
| buf_full | output | 1 | Registered full flag |
| buf_count | output | $clog2(DEPTH+1) | Registered occupancy |
| ad_out | output | 32 | Multiplexed address/data bus value |
| ad_oe | output | 1 | Bus drive enable |
| ale | output | 1 | Address latch strobe, address phase |
| addr_lo | output | 2 | Word address bits 3:2 of the current write |
| wr | output | 1 | Write strobe, data phase |
| data_en | output | 1 | External read-data enable, always low |
| wr_near | output | 1 | Current write stays in the previous write's 1 KB page |
| ack | input | 1 | Memory acknowledges the data phase |
| berr | input | 1 | Memory ends the data phase with an error |

## Verification
The bench fills the buffer while `ack` is held low and then keeps a fifth store pending. A design that took that store would overwrite the oldest entry or push the count past four. It checks addresses on both sides of a page boundary, including the last word of one page followed by the first word of the next. A comparator using too few or too many bits would tag the second write as near, or fail to tag same-page writes. It injects a bus error between two same-page stores, where a design that kept its page history would wrongly flag the next write as near. A design that left the errored entry in the buffer would repeat it or stall. Random ack delays with back-to-back stores catch a sequencer that drops into idle between queued writes, or one that pops the wrong entry when a store arrives in the same cycle a write ends.

// File: rtl/spb_pkg.sv
package spb_pkg;

    localparam int WORD_ADDR_W   = 30;
    localparam int DATA_W        = 32;
    localparam int BE_W          = 4;
    localparam int PAGE_WORD_LSB = 8;
    localparam int PAGE_W        = WORD_ADDR_W - PAGE_WORD_LSB;

    typedef struct packed {
        logic [WORD_ADDR_W-1:0] waddr;
        logic [DATA_W-1:0]      data;
        logic [BE_W-1:0]        be;
    } store_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_t;

    function automatic logic [PAGE_W-1:0] page_of(input logic [WORD_ADDR_W-1:0] w);
        return w[WORD_ADDR_W-1:PAGE_WORD_LSB];
    endfunction

    function automatic logic [DATA_W-1:0] addr_word(input store_t s);
        return {s.waddr[WORD_ADDR_W-1:2], s.be};
    endfunction

endpackage

// File: rtl/spb_fifo.sv
module spb_fifo
    import spb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  store_t                     din,
    input  logic                       pop,
    output store_t                     head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    store_t            slot [DEPTH];
    logic [PW-1:0]     rd_ptr;
    logic [PW-1:0]     wr_ptr;
    logic [CW-1:0]     count_q;
    logic [CW-1:0]     count_nx;
    logic              full_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (push && (wr_ptr == PW'(g))) begin
                    slot[g] <= din;
                end
            end
        end
    endgenerate

    always_comb begin
        count_nx = count_q + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            count_q <= '0;
            full_q  <= 1'b0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            count_q <= count_nx;
            full_q  <= (count_nx == CW'(DEPTH));
        end
    end

    assign head  = slot[rd_ptr];
    assign count = count_q;
    assign full  = full_q;

endmodule

// File: rtl/spb_bus_seq.sv
module spb_bus_seq
    import spb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              have_entry,
    input  logic              more_after,
    input  store_t            head,
    input  logic              ack,
    input  logic              berr,
    output logic              pop,
    output logic              busy,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              ale,
    output logic [1:0]        addr_lo,
    output logic              wr,
    output logic              data_en
);
    phase_t phase_q;
    phase_t phase_nx;
    logic   finish;

    assign finish = (phase_q == PH_DATA) && (ack || berr);

    always_comb begin
        phase_nx = phase_q;
        unique case (phase_q)
            PH_IDLE: if (have_entry) phase_nx = PH_ADDR;
            PH_ADDR: phase_nx = PH_DATA;
            PH_DATA: if (finish) phase_nx = more_after ? PH_ADDR : PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_nx;
    end

    always_comb begin
        ale     = (phase_q == PH_ADDR);
        wr      = (phase_q == PH_DATA);
        ad_oe   = ale || wr;
        busy    = ad_oe;
        data_en = 1'b0;
        addr_lo = busy ? head.waddr[1:0] : 2'b00;
        if (ale)     ad_out = addr_word(head);
        else if (wr) ad_out = head.data;
        else         ad_out = '0;
    end

    assign pop = finish;

endmodule

// File: rtl/spb_near_track.sv
module spb_near_track
    import spb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [WORD_ADDR_W-1:0] cur_waddr,
    input  logic                   retire,
    input  logic                   retire_err,
    output logic                   near
);
    logic [PAGE_W-1:0] last_page_q;
    logic              last_ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_page_q <= '0;
            last_ok_q   <= 1'b0;
        end else if (retire) begin
            last_page_q <= page_of(cur_waddr);
            last_ok_q   <= !retire_err;
        end
    end

    assign near = last_ok_q && (page_of(cur_waddr) == last_page_q);

endmodule

// File: rtl/store_post_buffer.sv
module store_post_buffer
    import spb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       st_valid,
    input  logic [29:0]                st_waddr,
    input  logic [31:0]                st_data,
    input  logic [3:0]                 st_be,
    output logic                       st_stall,
    output logic                       buf_full,
    output logic [$clog2(DEPTH+1)-1:0] buf_count,
    output logic [31:0]                ad_out,
    output logic                       ad_oe,
    output logic                       ale,
    output logic [1:0]                 addr_lo,
    output logic                       wr,
    output logic                       data_en,
    output logic                       wr_near,
    input  logic                       ack,
    input  logic                       berr
);
    localparam int CW = $clog2(DEPTH+1);

    store_t  in_store;
    store_t  head;
    logic    push;
    logic    pop;
    logic    busy;
    logic    near_raw;
    logic    more_after;

    assign in_store = '{waddr: st_waddr, data: st_data, be: st_be};
    assign push     = st_valid && !buf_full;
    assign st_stall = buf_full;
    assign more_after = (buf_count > CW'(1)) || push;

    spb_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   (in_store),
        .pop   (pop),
        .head  (head),
        .count (buf_count),
        .full  (buf_full)
    );

    spb_bus_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .have_entry (buf_count != '0),
        .more_after (more_after),
        .head       (head),
        .ack        (ack),
        .berr       (berr),
        .pop        (pop),
        .busy       (busy),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe),
        .ale        (ale),
        .addr_lo    (addr_lo),
        .wr         (wr),
        .data_en    (data_en)
    );

    spb_near_track u_near (
        .clk        (clk),
        .rst        (rst),
        .cur_waddr  (head.waddr),
        .retire     (pop),
        .retire_err (berr),
        .near       (near_raw)
    );

    assign wr_near = busy && near_raw;

endmodule

// File: rtl/spb_checker.sv
module spb_checker #(
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       st_valid,
    input logic                       buf_full,
    input logic [$clog2(DEPTH+1)-1:0] buf_count,
    input logic [31:0]                ad_out,
    input logic                       ad_oe,
    input logic                       ale,
    input logic [1:0]                 addr_lo,
    input logic                       wr,
    input logic                       wr_near,
    input logic                       ack,
    input logic                       berr
);
    localparam int CW = $clog2(DEPTH+1);

    AST_COUNT_MAX: assert property (@(posedge clk) disable iff (rst)
        buf_count <= CW'(DEPTH)); // R1

    AST_FULL_FLAG: assert property (@(posedge clk) disable iff (rst)
        buf_full == (buf_count == CW'(DEPTH))); // R2

    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
        (buf_full && st_valid) |=> (buf_count <= $past(buf_count))); // R2

    AST_ALE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale); // R3

    AST_ALE_NOT_WR: assert property (@(posedge clk) disable iff (rst)
        !(ale && wr)); // R3

    AST_ADDRLO_HELD: assert property (@(posedge clk) disable iff (rst)
        wr |-> $stable(addr_lo)); // R4

    AST_ALE_THEN_WR: assert property (@(posedge clk) disable iff (rst)
        ale |=> wr); // R5

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr && !ack && !berr) |=> (wr && $stable(ad_out))); // R5

    AST_NEAR_HELD: assert property (@(posedge clk) disable iff (rst)
        wr |-> $stable(wr_near)); // R6

    AST_OE_PHASES: assert property (@(posedge clk) disable iff (rst)
        ad_oe == (ale || wr)); // R8

endmodule

bind store_post_buffer spb_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .st_valid  (st_valid),
    .buf_full  (buf_full),
    .buf_count (buf_count),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .ale       (ale),
    .addr_lo   (addr_lo),
    .wr        (wr),
    .wr_near   (wr_near),
    .ack       (ack),
    .berr      (berr)
);

// File: tb/store_post_buffer_test.sv
module store_post_buffer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_valid = 1'b0;
    logic [29:0] st_waddr = '0;
    logic [31:0] st_data = '0;
    logic [3:0]  st_be = '0;
    logic        st_stall;
    logic        buf_full;
    logic [2:0]  buf_count;
    logic [31:0] ad_out;
    logic        ad_oe;
    logic        ale;
    logic [1:0]  addr_lo;
    logic        wr;
    logic        data_en;
    logic        wr_near;
    logic        ack = 1'b0;
    logic        berr = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int ack_mode = 2;
    bit berr_req = 0;

    logic [29:0] qa[$];
    logic [31:0] qd[$];
    logic [3:0]  qb[$];
    bit          last_ok = 0;
    logic [21:0] last_page = '0;
    bit          exp_ale_next = 0;

    store_post_buffer #(.DEPTH(4)) uut (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_waddr(st_waddr),
        .st_data(st_data), .st_be(st_be), .st_stall(st_stall),
        .buf_full(buf_full), .buf_count(buf_count), .ad_out(ad_out),
        .ad_oe(ad_oe), .ale(ale), .addr_lo(addr_lo), .wr(wr),
        .data_en(data_en), .wr_near(wr_near), .ack(ack), .berr(berr)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit exp_near(input logic [29:0] a);
        return last_ok && (a[29:8] == last_page);
    endfunction

    // Ack / error driver, away from the active edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (berr_req && wr) begin
                berr = 1'b1; ack = 1'b0; berr_req = 0;
            end else begin
                berr = 1'b0;
                case (ack_mode)
                    0: ack = 1'b0;
                    1: ack = ($urandom % 3) == 0;
                    default: ack = 1'b1;
                endcase
            end
        end
    end

    // Monitor and scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (exp_ale_next) begin
                chk("R10 next address phase", {31'd0, ale}, 32'd1);
                exp_ale_next = 0;
            end
            if (st_valid && !buf_full) begin
                qa.push_back(st_waddr);
                qd.push_back(st_data);
                qb.push_back(st_be);
            end
            if (!ale && !wr) begin
                chk("R8 idle drive", {30'd0, ad_oe, data_en}, 32'd0);
            end
            if (ale) begin
                if (qa.size() == 0) begin
                    chk("R1 unexpected write", 32'd1, 32'd0);
                end else begin
                    chk("R3 address bits", {ad_out[31:4], 4'd0}, {qa[0][29:2], 4'd0});
                    chk("R3 byte enables", {28'd0, ad_out[3:0]}, {28'd0, qb[0]});
                    chk("R3 wr low in address phase", {31'd0, wr}, 32'd0);
                    chk("R4 word bits", {30'd0, addr_lo}, {30'd0, qa[0][1:0]});
                    chk(last_ok ? "R6 near in address phase" : "R7 near after reset/error",
                        {31'd0, wr_near}, {31'd0, exp_near(qa[0])});
                end
            end
            if (wr && (ack || berr) && qa.size() != 0) begin
                chk(berr ? "R9 data on errored write" : "R5 data and order",
                    ad_out, qd[0]);
                chk("R4 word bits in data phase", {30'd0, addr_lo}, {30'd0, qa[0][1:0]});
                chk("R8 data_en", {31'd0, data_en}, 32'd0);
                chk("R6 near in data phase", {31'd0, wr_near}, {31'd0, exp_near(qa[0])});
                last_ok   = !berr;
                last_page = qa[0][29:8];
                void'(qa.pop_front());
                void'(qd.pop_front());
                void'(qb.pop_front());
                if (qa.size() != 0) exp_ale_next = 1;
            end
        end
    end

    task automatic push(input logic [29:0] a, input logic [31:0] d, input logic [3:0] b);
        bit acc;
        st_valid = 1'b1; st_waddr = a; st_data = d; st_be = b;
        do begin
            @(negedge clk);
            acc = !buf_full;
            @(posedge clk);
            #2;
        end while (!acc);
        st_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk);
            #2;
            if (buf_count == 0 && !ale && !wr && qa.size() == 0) return;
        end
        chk("R1 drain timeout", 32'd1, 32'd0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        chk("R1 reset count", {29'd0, buf_count}, 32'd0);
        chk("R2 reset full/stall", {30'd0, buf_full, st_stall}, 32'd0);
        chk("R8 reset bus idle", {28'd0, ale, wr, ad_oe, data_en}, 32'd0);
        @(posedge clk); #2;

        // Same page, then page boundary
        ack_mode = 2;
        push(30'h0040_0010, 32'hA0A0_0001, 4'hF);
        push(30'h0040_0011, 32'hA0A0_0002, 4'h3);
        push(30'h0040_00FF, 32'hA0A0_0003, 4'h8);
        push(30'h0040_0100, 32'hA0A0_0004, 4'h1);
        push(30'h0040_0101, 32'hA0A0_0005, 4'hC);
        drain();

        // Fill with no acknowledge
        ack_mode = 0;
        for (int i = 0; i < 4; i++) push(30'h0100_0000 + 30'(i), 32'hB000_0000 + i, 4'hF);
        chk("R1 count at full", {29'd0, buf_count}, 32'd4);
        chk("R2 full and stall", {30'd0, buf_full, st_stall}, 32'd3);
        st_valid = 1'b1; st_waddr = 30'h0100_0004; st_data = 32'hB000_0004; st_be = 4'h6;
        repeat (3) @(posedge clk);
        #2;
        chk("R2 store held while full", {29'd0, buf_count}, 32'd4);
        ack_mode = 1;
        push(30'h0100_0004, 32'hB000_0004, 4'h6);
        drain();

        // Bus error between same-page stores
        ack_mode = 2;
        berr_req = 1;
        push(30'h0200_0000, 32'hC000_0001, 4'hF);
        push(30'h0200_0001, 32'hC000_0002, 4'hF);
        push(30'h0200_0002, 32'hC000_0003, 4'hF);
        drain();

        // Random traffic
        ack_mode = 1;
        for (int n = 0; n < 400; n++) begin
            logic [21:0] pg;
            case ($urandom % 3)
                0: pg = 22'h00_1234;
                1: pg = 22'h00_1235;
                default: pg = 22'($urandom);
            endcase
            if (($urandom % 25) == 0) berr_req = 1;
            push({pg, 8'($urandom)}, $urandom, 4'($urandom));
            repeat ($urandom % 3) begin @(posedge clk); #2; end
        end
        drain();
        finish_run();
    end

endmodule